// File: doc/BRIEF.md
# Pipelined Program Sequencer with Branch Flush

This block generates program addresses for a three-stage instruction pipeline (fetch, decode, execute) and moves each fetched instruction through the stages. Branches are resolved when they reach execute. Three immediate branch kinds are supported: jump, call and return. Each kind has a normal form and a delayed form. A normal branch turns the two younger instructions into NOPs, so the pipeline loses two cycles. A delayed branch lets both of those instructions run, so no cycle is lost.

Call and return use an internal hardware stack of return addresses. A normal call saves the address that follows it. A delayed call saves the address that follows its two delay slots. A return that finds the stack empty raises a flag and does not redirect the pipeline. A call that finds the stack full raises a flag, saves nothing, and still branches.

Program memory lies outside the block. It returns the word addressed by `fetchAddr` within the same cycle, along with pre-decoded branch fields: the kind, a delay bit and an immediate target. The fetch address register serves as the memory's address register.

Top module: `seq_pipe_sequencer`

## Requirements
- R1: A synchronous reset sets `fetchAddr` to 0, makes decode and execute hold NOPs (`decodeValid`=0, `execValid`=0, `execInstr`=0), empties the return stack and clears both stack flags.
- R2: With no taken branch in execute, `fetchAddr` rises by one on every clock. An instruction fetched at address A enters decode on the next cycle and execute on the cycle after that, with `execAddr`=A.
- R3: The branch kind is encoded as 0 none, 1 jump, 2 call, 3 return, and `memBrDelayed`=1 marks the delayed form. While a normal jump is in execute, `fetchValid` is 0. On the next cycle `fetchAddr` equals the target, and execute holds a NOP for two cycles. The target reaches execute on the third cycle after the jump.
- R4: A normal call at address N pushes N+1 and branches with the same two-cycle loss. A normal return pops the top entry, fetches from it, and loses two cycles in the same way.
- R5: A delayed branch at N lets N+1 and N+2 execute on the two cycles after it. The target executes on the next cycle after those, and `fetchValid` stays 1.
- R6: A delayed call at N pushes N+3, so the matching return resumes after the delay slots.
- R7: A branch that sits in either delay slot of an executing delayed branch never executes. Its execute cycle shows `execValid`=0, and it causes no redirect.
- R8: The stack holds 8 entries. A call that executes while the stack is full raises `stackOverflow` for exactly one cycle, starting on the cycle after the call. The call still branches, and the 8 stored entries are unchanged.
- R9: A return that executes while the stack is empty raises `stackUnderflow` for one cycle, starting on the cycle after the return. The return does not redirect and squashes nothing, so the next sequential instruction executes on the following cycle.
- R10: The NOP encoding is all zeros: `execInstr` reads 0 whenever `execValid` is 0, and otherwise shows the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetchAddr | output | ADDR_W | Address presented to program memory |
| memInstr | input | INSTR_W | Instruction word at `fetchAddr` |
| memBrKind | input | 2 | Branch kind of that word (0 none, 1 jump, 2 call, 3 return) |
| memBrDelayed | input | 1 | Word is a delayed branch |
| memBrTarget | input | ADDR_W | Immediate branch target of that word |
| fetchValid | output | 1 | The word being fetched this cycle is kept |
| decodeValid | output | 1 | Decode stage holds a real instruction |
| execValid | output | 1 | Execute stage holds a real instruction |
| execAddr | output | ADDR_W | Address of the instruction in execute |
| execInstr | output | INSTR_W | Instruction in execute, zero for NOP |
| stackOverflow | output | 1 | One-cycle pulse: push attempted on a full stack |
| stackUnderflow | output | 1 | One-cycle pulse: pop attempted on an empty stack |

## Verification
A wrong stage-valid bit or a wrong squash decision shows within one or two cycles, as a wrong `execValid` or a wrong `execAddr` sequence. A wrong PC selection shows on `fetchAddr` on the very next cycle. Stack faults can stay hidden for much longer, because a corrupted entry or pointer is only seen when the matching return executes. For this reason the bench nests calls to full depth and then unwinds them all, which checks every stored entry in order and also checks the empty-stack return at the end.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Number of instructions behind a branch that a delayed branch lets run.
  localparam int DELAY_SLOTS = 2;

  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_JUMP = 2'd1,
    BR_CALL = 2'd2,
    BR_RET  = 2'd3
  } brKind_e;

  // Strobes from the control module to the datapath and the stack.
  typedef struct packed {
    logic redirect;   // load PC from target or stack top
    logic useStack;   // redirect source is the stack top
    logic killD;      // decode content becomes NOP when it moves to execute
    logic killF;      // fetched word becomes NOP when it moves to decode
    logic push;       // call wants to save a return address
    logic pushSkip;   // saved address skips the delay slots
    logic pop;        // return wants the stack top
  } ctrlStrobe_t;

endpackage

// File: rtl/seq_pc_stack.sv
module seq_pc_stack #(
  parameter int AW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] pushData,
  input  logic          pop,
  output logic [AW-1:0] topData,
  output logic          empty,
  output logic          overflow,
  output logic          underflow
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] below;
  logic          full;

  assign full    = (ptr == FULL_CNT);
  assign empty   = (ptr == '0);
  assign below   = ptr - 1'b1;
  assign topData = mem[below[SW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= push && full;
      underflow <= pop && empty;
      if (push && !full)
        ptr <= ptr + 1'b1;
      else if (pop && !empty)
        ptr <= ptr - 1'b1;
    end
  end

  // Storage needs no reset: the pointer decides what is readable.
  always_ff @(posedge clk) begin
    if (!rst && push && !full)
      mem[ptr[SW-1:0]] <= pushData;
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic        exValid,
  input  brKind_e     exKind,
  input  logic        exDelayed,
  input  brKind_e     decKind,
  input  brKind_e     fetchKind,
  input  logic        stackEmpty,
  output ctrlStrobe_t ctrl
);

  logic isBr;
  logic retBlocked;
  logic taken;
  logic flush;
  logic slotRule;

  always_comb begin
    isBr       = exValid && (exKind != BR_NONE);
    retBlocked = (exKind == BR_RET) && stackEmpty;
    taken      = isBr && !retBlocked;
    flush      = taken && !exDelayed;
    // Any executing delayed branch makes branches in its slots illegal.
    slotRule   = isBr && exDelayed;

    ctrl.redirect = taken;
    ctrl.useStack = taken && (exKind == BR_RET);
    ctrl.killD    = flush || (slotRule && (decKind != BR_NONE));
    ctrl.killF    = flush || (slotRule && (fetchKind != BR_NONE));
    ctrl.push     = taken && (exKind == BR_CALL);
    ctrl.pushSkip = exDelayed;
    ctrl.pop      = isBr && (exKind == BR_RET);
  end

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int AW = 12,
  parameter int IW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrlStrobe_t   ctrl,
  input  logic [IW-1:0] memInstr,
  input  brKind_e       memKind,
  input  logic          memDelayed,
  input  logic [AW-1:0] memTarget,
  input  logic [AW-1:0] stackTop,
  output logic [AW-1:0] pc,
  output logic          decValid,
  output brKind_e       decKind,
  output logic          exValid,
  output brKind_e       exKind,
  output logic          exDelayed,
  output logic [AW-1:0] exAddr,
  output logic [IW-1:0] exInstrOut,
  output logic [AW-1:0] pushData
);

  localparam logic [AW-1:0] STEP_NEXT = AW'(1);
  localparam logic [AW-1:0] STEP_SKIP = AW'(DELAY_SLOTS + 1);

  // decode stage
  logic [AW-1:0] decAddr;
  logic [IW-1:0] decInstr;
  logic          decDelayed;
  logic [AW-1:0] decTarget;
  // execute stage
  logic [IW-1:0] exInstr;
  logic [AW-1:0] exTarget;

  logic [AW-1:0] pcNext;

  always_comb begin
    if (ctrl.redirect)
      pcNext = ctrl.useStack ? stackTop : exTarget;
    else
      pcNext = pc + STEP_NEXT;
  end

  assign pushData   = exAddr + (ctrl.pushSkip ? STEP_SKIP : STEP_NEXT);
  assign exInstrOut = exValid ? exInstr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      decValid   <= 1'b0;
      decKind    <= BR_NONE;
      decAddr    <= '0;
      decInstr   <= '0;
      decDelayed <= 1'b0;
      decTarget  <= '0;
      exValid    <= 1'b0;
      exKind     <= BR_NONE;
      exDelayed  <= 1'b0;
      exAddr     <= '0;
      exInstr    <= '0;
      exTarget   <= '0;
    end else begin
      pc         <= pcNext;
      // fetch -> decode
      decValid   <= !ctrl.killF;
      decKind    <= memKind;
      decAddr    <= pc;
      decInstr   <= memInstr;
      decDelayed <= memDelayed;
      decTarget  <= memTarget;
      // decode -> execute
      exValid    <= decValid && !ctrl.killD;
      exKind     <= decKind;
      exDelayed  <= decDelayed;
      exAddr     <= decAddr;
      exInstr    <= decInstr;
      exTarget   <= decTarget;
    end
  end

endmodule

// File: rtl/seq_pipe_sequencer.sv
module seq_pipe_sequencer
  import seq_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int INSTR_W     = 24,
  parameter int STACK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  fetchAddr,
  input  logic [INSTR_W-1:0] memInstr,
  input  logic [1:0]         memBrKind,
  input  logic               memBrDelayed,
  input  logic [ADDR_W-1:0]  memBrTarget,
  output logic               fetchValid,
  output logic               decodeValid,
  output logic               execValid,
  output logic [ADDR_W-1:0]  execAddr,
  output logic [INSTR_W-1:0] execInstr,
  output logic               stackOverflow,
  output logic               stackUnderflow
);

  ctrlStrobe_t       ctrlS;
  brKind_e           fetchKind;
  brKind_e           decKind;
  brKind_e           exKind;
  logic              exDelayed;
  logic [ADDR_W-1:0] stackTop;
  logic [ADDR_W-1:0] pushData;
  logic              stackEmpty;

  assign fetchKind  = brKind_e'(memBrKind);
  assign fetchValid = !ctrlS.killF;

  seq_ctrl ctrl_i (
    .exValid    (execValid),
    .exKind     (exKind),
    .exDelayed  (exDelayed),
    .decKind    (decKind),
    .fetchKind  (fetchKind),
    .stackEmpty (stackEmpty),
    .ctrl       (ctrlS)
  );

  seq_datapath #(.AW(ADDR_W), .IW(INSTR_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrlS),
    .memInstr   (memInstr),
    .memKind    (fetchKind),
    .memDelayed (memBrDelayed),
    .memTarget  (memBrTarget),
    .stackTop   (stackTop),
    .pc         (fetchAddr),
    .decValid   (decodeValid),
    .decKind    (decKind),
    .exValid    (execValid),
    .exKind     (exKind),
    .exDelayed  (exDelayed),
    .exAddr     (execAddr),
    .exInstrOut (execInstr),
    .pushData   (pushData)
  );

  seq_pc_stack #(.AW(ADDR_W), .DEPTH(STACK_DEPTH)) stack_i (
    .clk       (clk),
    .rst       (rst),
    .push      (ctrlS.push),
    .pushData  (pushData),
    .pop       (ctrlS.pop),
    .topData   (stackTop),
    .empty     (stackEmpty),
    .overflow  (stackOverflow),
    .underflow (stackUnderflow)
  );

endmodule

// File: rtl/seq_pipe_sequencer_chk.sv
module seq_pipe_sequencer_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] fetchAddr,
  input logic          fetchValid,
  input logic          decodeValid,
  input logic          execValid,
  input logic          stackOverflow,
  input logic          stackUnderflow,
  input logic          redirect,
  input logic          exDelayed
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fetchAddr == '0) && !decodeValid && !execValid);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> fetchAddr == $past(fetchAddr) + 1'b1);

  assert_fetch_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (redirect && !exDelayed) |-> !fetchValid);

  assert_flush_R3: assert property (@(posedge clk) disable iff (rst)
    (redirect && !exDelayed) |=> !decodeValid && !execValid);

  assert_ovf_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    stackOverflow |=> !stackOverflow);

  assert_unf_no_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    stackUnderflow |-> fetchAddr == $past(fetchAddr) + 1'b1);

endmodule

bind seq_pipe_sequencer seq_pipe_sequencer_chk #(.AW(ADDR_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .fetchAddr      (fetchAddr),
  .fetchValid     (fetchValid),
  .decodeValid    (decodeValid),
  .execValid      (execValid),
  .stackOverflow  (stackOverflow),
  .stackUnderflow (stackUnderflow),
  .redirect       (ctrlS.redirect),
  .exDelayed      (exDelayed)
);

// File: tb/seq_pipe_sequencer_tb.sv
module seq_pipe_sequencer_tb_top;

  localparam int AW = 12;
  localparam int IW = 24;
  localparam int MEMN = 256;
  localparam int WATCHDOG = 5000;

  localparam logic [1:0] K_NONE = 2'd0, K_JUMP = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  // Trace row: {fetchAddr[7:0], fetchValid, decodeValid, execValid, execAddr[7:0]}
  localparam logic [18:0] TRACE [24] = '{
    {8'd0,  1'b1, 1'b0, 1'b0, 8'd0 },
    {8'd1,  1'b1, 1'b1, 1'b0, 8'd0 },
    {8'd2,  1'b1, 1'b1, 1'b1, 8'd0 },
    {8'd3,  1'b1, 1'b1, 1'b1, 8'd1 },
    {8'd4,  1'b0, 1'b1, 1'b1, 8'd2 },
    {8'd10, 1'b1, 1'b0, 1'b0, 8'd0 },
    {8'd11, 1'b1, 1'b1, 1'b0, 8'd0 },
    {8'd12, 1'b1, 1'b1, 1'b1, 8'd10},
    {8'd20, 1'b1, 1'b1, 1'b1, 8'd11},
    {8'd21, 1'b1, 1'b1, 1'b1, 8'd12},
    {8'd22, 1'b0, 1'b1, 1'b1, 8'd20},
    {8'd13, 1'b1, 1'b0, 1'b0, 8'd0 },
    {8'd14, 1'b1, 1'b1, 1'b0, 8'd0 },
    {8'd15, 1'b0, 1'b1, 1'b1, 8'd13},
    {8'd30, 1'b1, 1'b0, 1'b0, 8'd0 },
    {8'd31, 1'b1, 1'b1, 1'b0, 8'd0 },
    {8'd32, 1'b1, 1'b1, 1'b1, 8'd30},
    {8'd40, 1'b1, 1'b1, 1'b0, 8'd0 },
    {8'd41, 1'b1, 1'b1, 1'b1, 8'd32},
    {8'd42, 1'b1, 1'b1, 1'b1, 8'd40},
    {8'd14, 1'b1, 1'b1, 1'b1, 8'd41},
    {8'd15, 1'b1, 1'b1, 1'b1, 8'd42},
    {8'd16, 1'b1, 1'b1, 1'b1, 8'd14},
    {8'd17, 1'b1, 1'b1, 1'b1, 8'd15}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetchAddr;
  logic [IW-1:0] memInstr;
  logic [1:0]    memBrKind;
  logic          memBrDelayed;
  logic [AW-1:0] memBrTarget;
  logic          fetchValid, decodeValid, execValid;
  logic [AW-1:0] execAddr;
  logic [IW-1:0] execInstr;
  logic          stackOverflow, stackUnderflow;

  logic [IW-1:0] romWord   [MEMN];
  logic [1:0]    romKind   [MEMN];
  logic          romDelay  [MEMN];
  logic [AW-1:0] romTarget [MEMN];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign memInstr     = romWord[fetchAddr[7:0]];
  assign memBrKind    = romKind[fetchAddr[7:0]];
  assign memBrDelayed = romDelay[fetchAddr[7:0]];
  assign memBrTarget  = romTarget[fetchAddr[7:0]];

  seq_pipe_sequencer dut_i (
    .clk            (clk),
    .rst            (rst),
    .fetchAddr      (fetchAddr),
    .memInstr       (memInstr),
    .memBrKind      (memBrKind),
    .memBrDelayed   (memBrDelayed),
    .memBrTarget    (memBrTarget),
    .fetchValid     (fetchValid),
    .decodeValid    (decodeValid),
    .execValid      (execValid),
    .execAddr       (execAddr),
    .execInstr      (execInstr),
    .stackOverflow  (stackOverflow),
    .stackUnderflow (stackUnderflow)
  );

  function automatic logic [IW-1:0] wordAt(int a);
    return 24'h5A0000 | IW'(a);
  endfunction

  function automatic string rowTag(int c);
    if (c < 4) return "R2";
    if (c < 7) return "R3";
    if (c < 10) return "R6";
    if (c < 16) return "R4";
    if (c < 19) return "R7";
    if (c < 22) return "R5";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearRom();
    for (int a = 0; a < MEMN; a++) begin
      romWord[a]   = wordAt(a);
      romKind[a]   = K_NONE;
      romDelay[a]  = 1'b0;
      romTarget[a] = '0;
    end
  endtask

  task automatic setBr(int a, logic [1:0] k, logic d, int t);
    romKind[a]   = k;
    romDelay[a]  = d;
    romTarget[a] = AW'(t);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic checkResetState(string what);
    check("R1", {what, " fetchAddr"}, 32'(fetchAddr), 32'd0);
    check("R1", {what, " decodeValid"}, 32'(decodeValid), 32'd0);
    check("R1", {what, " execValid"}, 32'(execValid), 32'd0);
    check("R1", {what, " execInstr"}, 32'(execInstr), 32'd0);
    check("R1", {what, " flags"}, 32'({stackOverflow, stackUnderflow}), 32'd0);
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [18:0] row;
    int execSeq [20];
    int nExec;
    int expSeq [20];
    bit prevV;
    int prevA;
    int spurious;

    // ---------- program 1: trace table ----------
    clearRom();
    setBr(2,  K_JUMP, 1'b0, 10);
    setBr(10, K_CALL, 1'b1, 20);
    setBr(20, K_RET,  1'b0, 0);
    setBr(13, K_CALL, 1'b0, 30);
    setBr(30, K_JUMP, 1'b1, 40);
    setBr(31, K_JUMP, 1'b0, 50);   // illegal: sits in a delay slot
    setBr(40, K_RET,  1'b1, 0);

    repeat (3) @(negedge clk);
    checkResetState("held in reset");
    rst = 1'b0;

    for (int c = 0; c < 24; c++) begin
      row = TRACE[c];
      check(rowTag(c), $sformatf("cycle %0d fetchAddr", c), 32'(fetchAddr), 32'(row[18:11]));
      check(rowTag(c), $sformatf("cycle %0d fetchValid", c), 32'(fetchValid), 32'(row[10]));
      check(rowTag(c), $sformatf("cycle %0d decodeValid", c), 32'(decodeValid), 32'(row[9]));
      check(rowTag(c), $sformatf("cycle %0d execValid", c), 32'(execValid), 32'(row[8]));
      if (row[8]) begin
        check(rowTag(c), $sformatf("cycle %0d execAddr", c), 32'(execAddr), 32'(row[7:0]));
        check("R10", $sformatf("cycle %0d execInstr word", c), 32'(execInstr), 32'(wordAt(int'(row[7:0]))));
      end else begin
        check("R10", $sformatf("cycle %0d execInstr NOP", c), 32'(execInstr), 32'd0);
      end
      check("R8", $sformatf("cycle %0d no overflow", c), 32'(stackOverflow), 32'd0);
      check("R9", $sformatf("cycle %0d no underflow", c), 32'(stackUnderflow), 32'd0);
      @(negedge clk);
    end

    // ---------- reset in the middle of a run ----------
    doReset();
    checkResetState("mid-run reset");

    // ---------- program 2: nested calls to overflow, unwind to underflow ----------
    clearRom();
    for (int k = 0; k < 9; k++) setBr(16 * k, K_CALL, 1'b0, 16 * (k + 1));
    for (int k = 0; k < 8; k++) setBr(16 * k + 1, K_RET, 1'b0, 0);
    setBr(144, K_RET, 1'b0, 0);

    for (int k = 0; k < 9; k++) expSeq[k] = 16 * k;
    expSeq[9] = 144;
    for (int k = 0; k < 8; k++) expSeq[10 + k] = 16 * (7 - k) + 1;
    expSeq[18] = 2;
    expSeq[19] = 3;

    rst = 1'b0;
    nExec = 0;
    prevV = 1'b0;
    prevA = 0;
    spurious = 0;
    for (int c = 0; c < 75; c++) begin
      if (prevV && prevA == 128) begin
        check("R8", "overflow pulse after full-stack call", 32'(stackOverflow), 32'd1);
      end else if (stackOverflow) begin
        spurious++;
      end
      if (prevV && prevA == 1) begin
        check("R9", "underflow pulse after empty-stack return", 32'(stackUnderflow), 32'd1);
        check("R9", "next instruction executes without loss", 32'({execValid, execAddr}), 32'({1'b1, 12'd2}));
      end else if (stackUnderflow) begin
        spurious++;
      end
      if (execValid && nExec < 20) begin
        execSeq[nExec] = int'(execAddr);
        nExec++;
      end
      prevV = execValid;
      prevA = int'(execAddr);
      @(negedge clk);
    end
    check("R8", "no extra flag pulses", 32'(spurious), 32'd0);
    check("R8", "executed instruction count", 32'(nExec), 32'd20);
    for (int k = 0; k < 20; k++) begin
      check(k < 10 ? "R4" : "R8", $sformatf("execute order slot %0d", k),
            32'(execSeq[k]), 32'(expSeq[k]));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule